// File: doc/BRIEF.md
# Guarded Dual Saturating Halfword Adder

This block is the execution pipe for a single packed-SIMD operation. Each 32-bit source word holds two signed 16-bit lanes. The block adds the matching lanes of the two sources at full precision and clamps each lane sum to the signed 16-bit range. It then packs the two clamped lanes back into one 32-bit result.

An issue strobe brings in the two sources, a destination register index, a guard word and a flag that says whether the operation is guarded. The block sends a write-enable, a write index and write data toward a register file. These outputs appear a fixed two cycles after issue. A guarded operation whose guard has a clear bit 0 produces no write, so the destination keeps its old value.

The pipe takes a new operation every cycle and never stalls. The issue side therefore has no ready signal and no back-pressure: every operation accepted in cycle t reaches the write port in cycle t+2. The register file must accept one write per cycle.

Top module: `hds_dual_sat_add`

## Requirements
- R1: Result bits 15:0 are the sum of source bits 15:0. Both halfwords are sign-extended to 17 bits before the add, and the sum is then clamped to the signed 16-bit range.
- R2: Result bits 31:16 are the clamped sum of source bits 31:16, computed in the same way.
- R3: A lane sum greater than 32767 gives 0x7fff in that lane. A sum of exactly 32767 passes through unchanged.
- R4: A lane sum less than -32768 gives 0x8000 in that lane. A sum of exactly -32768 passes through unchanged.
- R5: Each lane is clamped on its own, so one lane saturating never changes the other lane.
- R6: `wr_en` is 1 in cycle t+2 exactly when an issue in cycle t had `iss_vld`=1 and either `iss_guarded`=0 or `guard_w[0]`=1. Bits 31:1 of `guard_w` have no effect, and an idle cycle gives no write.
- R7: A guarded issue with `guard_w[0]`=0 gives `wr_en`=0 two cycles later, so the destination keeps its old value.
- R8: `wr_idx` in cycle t+2 equals the `iss_dst` value issued in cycle t. Operations issued in consecutive cycles each arrive with their own index and data.
- R9: A synchronous active-high `rst` clears every pipeline valid bit. `wr_en` stays 0 during reset and for the two cycles after it, even when operations were in flight at the time of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| iss_vld | input | 1 | Issue strobe, one operation per cycle |
| iss_guarded | input | 1 | 1 when the operation carries a guard |
| src_a | input | 32 | First source, two signed 16-bit lanes |
| src_b | input | 32 | Second source, two signed 16-bit lanes |
| guard_w | input | 32 | Guard word; only bit 0 is used |
| iss_dst | input | 7 | Destination register index |
| wr_en | output | 1 | Register file write enable |
| wr_idx | output | 7 | Register file write index |
| wr_data | output | 32 | Packed clamped result |

## Verification
The bench drives sums that land exactly on +32767 and -32768. A design that clamps one step early would change these values. It also drives sums one step past each limit, and a design that takes only the low 16 bits would wrap them to the opposite sign. Mixed vectors, with one lane overflowing up and the other down or not at all, expose a design that shares one overflow flag between the lanes or swaps the lane order. Guard words with bit 0 clear but upper bits set, and odd guard words, catch a design that tests the whole word instead of bit 0. Finally, a reset asserted while two operations are in flight catches a pipe that lets a stale write escape after reset.

// File: rtl/hds_pkg.sv
package hds_pkg;

  // Fixed issue-to-write latency of the pipe, in cycles.
  localparam int unsigned HDS_LATENCY = 2;

  // An operation commits when issued and either unguarded or guard bit 0 set.
  function automatic logic commit_ok(input logic vld, input logic guarded, input logic g0);
    return vld & (~guarded | g0);
  endfunction

endpackage

// File: rtl/hds_lane_add.sv
module hds_lane_add #(
  parameter int LANE_W = 16
) (
  input  logic [LANE_W-1:0] x,
  input  logic [LANE_W-1:0] y,
  output logic [LANE_W:0]   sum
);
  // Widen both operands by sign extension, so the sum cannot wrap.
  always_comb begin
    sum = {x[LANE_W-1], x} + {y[LANE_W-1], y};
  end
endmodule

// File: rtl/hds_lane_clip.sv
module hds_lane_clip #(
  parameter int LANE_W = 16
) (
  input  logic [LANE_W:0]   sum,
  output logic [LANE_W-1:0] q
);
  localparam logic [LANE_W-1:0] MAX_V = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] MIN_V = {1'b1, {(LANE_W-1){1'b0}}};

  logic ovf;

  always_comb begin
    // The top two bits differ only when the sum lies outside the narrow range.
    ovf = sum[LANE_W] ^ sum[LANE_W-1];
    if (ovf) q = sum[LANE_W] ? MIN_V : MAX_V;
    else     q = sum[LANE_W-1:0];
  end
endmodule

// File: rtl/hds_ctl_pipe.sv
module hds_ctl_pipe #(
  parameter int IDX_W = 7,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [IDX_W-1:0] in_idx,
  output logic             out_vld,
  output logic [IDX_W-1:0] out_idx
);
  logic [DEPTH-1:0]            vld_q;
  logic [DEPTH-1:0][IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else begin
      vld_q[0] <= in_vld;
      for (int s = 1; s < DEPTH; s++) vld_q[s] <= vld_q[s-1];
    end
    idx_q[0] <= in_idx;
    for (int s = 1; s < DEPTH; s++) idx_q[s] <= idx_q[s-1];
  end

  assign out_vld = vld_q[DEPTH-1];
  assign out_idx = idx_q[DEPTH-1];
endmodule

// File: rtl/hds_dual_sat_add.sv
module hds_dual_sat_add #(
  parameter int LANE_W = 16,
  parameter int LANES  = 2,
  parameter int IDX_W  = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    iss_vld,
  input  logic                    iss_guarded,
  input  logic [LANE_W*LANES-1:0] src_a,
  input  logic [LANE_W*LANES-1:0] src_b,
  input  logic [LANE_W*LANES-1:0] guard_w,
  input  logic [IDX_W-1:0]        iss_dst,
  output logic                    wr_en,
  output logic [IDX_W-1:0]        wr_idx,
  output logic [LANE_W*LANES-1:0] wr_data
);
  localparam int WORD_W = LANE_W * LANES;

  logic                    commit_s0;
  logic                    unused_guard_hi;
  logic [LANES-1:0][LANE_W:0] sum_s0;
  logic [LANES-1:0][LANE_W:0] sum_s1;
  logic [WORD_W-1:0]       clip_s1;

  assign commit_s0       = hds_pkg::commit_ok(iss_vld, iss_guarded, guard_w[0]);
  assign unused_guard_hi = ^guard_w[WORD_W-1:1];

  // Stage 0: full-precision lane sums.
  for (genvar g = 0; g < LANES; g++) begin : g_add
    hds_lane_add #(.LANE_W(LANE_W)) u_add (
      .x   (src_a[g*LANE_W +: LANE_W]),
      .y   (src_b[g*LANE_W +: LANE_W]),
      .sum (sum_s0[g])
    );
  end

  always_ff @(posedge clk) begin
    sum_s1 <= sum_s0;
  end

  // Stage 1: per-lane clamp, then register the packed word.
  for (genvar g = 0; g < LANES; g++) begin : g_clip
    hds_lane_clip #(.LANE_W(LANE_W)) u_clip (
      .sum (sum_s1[g]),
      .q   (clip_s1[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    wr_data <= clip_s1;
  end

  hds_ctl_pipe #(.IDX_W(IDX_W), .DEPTH(hds_pkg::HDS_LATENCY)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (commit_s0),
    .in_idx  (iss_dst),
    .out_vld (wr_en),
    .out_idx (wr_idx)
  );
endmodule

// File: rtl/hds_dual_sat_add_chk.sv
module hds_dual_sat_add_chk #(
  parameter int LANE_W = 16,
  parameter int LANES  = 2,
  parameter int IDX_W  = 7
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    iss_vld,
  input logic                    iss_guarded,
  input logic                    guard_lsb,
  input logic [LANE_W*LANES-1:0] src_a,
  input logic [LANE_W*LANES-1:0] src_b,
  input logic [IDX_W-1:0]        iss_dst,
  input logic                    wr_en,
  input logic [IDX_W-1:0]        wr_idx,
  input logic [LANE_W*LANES-1:0] wr_data
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  function automatic logic [LANE_W-1:0] ref_sat(input logic [LANE_W-1:0] x,
                                                input logic [LANE_W-1:0] y);
    longint s, hi, lo;
    s  = longint'($signed(x)) + longint'($signed(y));
    hi = (longint'(1) <<< (LANE_W-1)) - 1;
    lo = -hi - 1;
    if (s > hi) s = hi;
    else if (s < lo) s = lo;
    return s[LANE_W-1:0];
  endfunction

  // R9
  no_wr_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd2) |-> !wr_en);

  // R6
  wr_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && $past(iss_vld, 2) && (!$past(iss_guarded, 2) || $past(guard_lsb, 2)))
    |-> wr_en);

  // R7
  no_wr_guard_false_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && $past(iss_guarded, 2) && !$past(guard_lsb, 2)) |-> !wr_en);

  // R6
  no_wr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && !$past(iss_vld, 2)) |-> !wr_en);

  // R8
  idx_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && wr_en) |-> (wr_idx == $past(iss_dst, 2)));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // R1 R2 R3 R4 R5
    lane_sat_chk: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd2 && wr_en) |->
      (wr_data[g*LANE_W +: LANE_W] ==
       ref_sat($past(src_a[g*LANE_W +: LANE_W], 2), $past(src_b[g*LANE_W +: LANE_W], 2))));
  end
endmodule

bind hds_dual_sat_add hds_dual_sat_add_chk #(
  .LANE_W(LANE_W), .LANES(LANES), .IDX_W(IDX_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .iss_vld     (iss_vld),
  .iss_guarded (iss_guarded),
  .guard_lsb   (guard_w[0]),
  .src_a       (src_a),
  .src_b       (src_b),
  .iss_dst     (iss_dst),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_data     (wr_data)
);

// File: tb/sim_hds_dual_sat_add.sv
`timescale 1ns/1ps
module sim_hds_dual_sat_add;
  localparam int N = 12;

  // Table columns: source a, source b, guard word, guarded flag, expected data, expected write.
  localparam logic [31:0] TA [N] = '{32'h12340032, 32'h80000001, 32'h00017fff, 32'h7fff8000,
                                     32'h80008000, 32'hffffffff, 32'h7ffe0005, 32'h8001fff0,
                                     32'h40001000, 32'hc0000100, 32'h12340032, 32'h00050006};
  localparam logic [31:0] TB [N] = '{32'h00010002, 32'hffff7fff, 32'h7fff7fff, 32'h00018000,
                                     32'h80008000, 32'h00010001, 32'h0001fffb, 32'hffff0010,
                                     32'h40000234, 32'hbfff0200, 32'h00010002, 32'h00070008};
  localparam logic [31:0] TG [N] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
                                     32'h00000001, 32'h00000000, 32'hfffffffe, 32'h00000003};
  localparam logic        TH [N] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                     1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic [31:0] TX [N] = '{32'h12350034, 32'h80007fff, 32'h7fff7fff, 32'h7fff8000,
                                     32'h80008000, 32'h00000000, 32'h7fff0000, 32'h80000000,
                                     32'h7fff1234, 32'h80000300, 32'h00000000, 32'h000c000e};
  localparam logic        TW [N] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                                     1'b1, 1'b0, 1'b0, 1'b1};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iss_vld = 1'b0;
  logic        iss_guarded = 1'b0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [31:0] guard_w = '0;
  logic [6:0]  iss_dst = '0;
  logic        wr_en;
  logic [6:0]  wr_idx;
  logic [31:0] wr_data;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  hds_dual_sat_add u0 (
    .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_guarded(iss_guarded),
    .src_a(src_a), .src_b(src_b), .guard_w(guard_w), .iss_dst(iss_dst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] idx_of(input int i);
    return 7'((i * 9 + 3) % 128);
  endfunction

  task automatic drive(input int i);
    iss_vld     = 1'b1;
    src_a       = TA[i];
    src_b       = TB[i];
    guard_w     = TG[i];
    iss_guarded = TH[i];
    iss_dst     = idx_of(i);
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(); tick(); tick();
    // R9 reset state: no write while reset is held
    check_eq("R9 wr_en in reset", {31'b0, wr_en}, 32'h0);
    rst = 1'b0;

    // Back-to-back table walk; output for vector i appears two cycles later (R8)
    for (int i = 0; i < N + 2; i++) begin
      if (i >= 2) begin
        // R6 R7 write enable, guard bit 0 only
        check_eq($sformatf("R6 R7 wr_en vec %0d", i-2), {31'b0, wr_en}, {31'b0, TW[i-2]});
        if (TW[i-2]) begin
          // R1 R2 R3 R4 R5 packed clamped data
          check_eq($sformatf("R1 R2 R3 R4 R5 data vec %0d", i-2), wr_data, TX[i-2]);
          // R8 index follows its operation
          check_eq($sformatf("R8 idx vec %0d", i-2), {25'b0, wr_idx}, {25'b0, idx_of(i-2)});
        end
      end
      if (i < N) drive(i);
      else iss_vld = 1'b0;
      tick();
    end
    // R6 idle cycle issues no write
    check_eq("R6 idle no write", {31'b0, wr_en}, 32'h0);

    // R9 reset with two operations in flight
    drive(0);
    tick();
    drive(1);
    rst = 1'b1;
    tick();
    check_eq("R9 flush cycle 0", {31'b0, wr_en}, 32'h0);
    rst = 1'b0;
    iss_vld = 1'b0;
    tick();
    check_eq("R9 flush cycle 1", {31'b0, wr_en}, 32'h0);
    tick();
    check_eq("R9 flush cycle 2", {31'b0, wr_en}, 32'h0);

    // R9 recovery: pipe works again after reset
    drive(1);
    tick();
    iss_vld = 1'b0;
    tick();
    check_eq("R9 recovery wr_en", {31'b0, wr_en}, 32'h1);
    check_eq("R3 R4 recovery data", wr_data, 32'h80007fff);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule